// File: doc/BRIEF.md
# I2C Transfer FIFO Pair with Trigger Flags

This block buffers data bytes between a processor-visible register port and the byte engine of an I2C controller. It holds two byte queues, one feeding the engine for transmission and one collecting bytes the engine receives. Software writes outgoing bytes and reads incoming bytes through a single data register. It also reads both fill levels and sets the levels at which each direction raises its flag.

Three event flags tell software when to act. The transmit flag means the outgoing queue has drained to its programmed low-water mark. The receive flag means the incoming queue has reached its programmed high-water mark. The end flag means the engine finished a byte and found nothing more to send. Each flag can be routed to a single interrupt line. While the receive flag or the end flag is set, the block asks the engine to hold the bus clock low, so software can prepare the next message before the bus moves on. Two sticky error bits record a push that was refused because a queue was full and a pop that was refused because a queue was empty.

Top module: `i2c_fifo_pair`

## Requirements
- R1: While reset is asserted, both fill counts, the control register, the enable register and the status register read 0. `irq` and `eng_hold` are 0, `eng_tx_avail` is 0 and `eng_rx_room` is 1.
- R2: Register map: 0 data, 1 control, 2 status, 3 enable, 4 receive count, 5 transmit count. Each queue holds 16 bytes and gives them out in the order they came in. A write to address 0 feeds the transmit queue and a read of address 0 takes from the receive queue. `eng_tx_pop` takes from the transmit queue, whose head is on `eng_tx_byte`. `eng_rx_push` stores `eng_rx_byte`. Address 4 reads the receive fill level and address 5 reads the transmit fill level.
- R3: Writing 1 to control bit 1 empties the receive queue, and writing 1 to control bit 0 empties the transmit queue. Neither write touches the other queue. Both bits read back as 0.
- R4: Control bits [7:4] hold a value N. Status bit 1 becomes set one cycle after the receive count is N+1 or more.
- R5: Control bits [3:2] hold a code that selects a low-water mark: code 0 is 8 bytes, 1 is 4, 2 is 2 and 3 is 0. Status bit 0 becomes set one cycle after the transmit count is at or below that mark.
- R6: Status bit 2 becomes set one cycle after `eng_tx_sent` is seen while the transmit queue is empty.
- R7: A status write clears each bit written as 0 and leaves each bit written as 1. If a flag's setting condition still holds, that flag is set again.
- R8: `irq` is high when any of status bits [2:0] is set and the matching bit of enable register bits [2:0] is also set.
- R9: `eng_hold` is high while status bit 1 or status bit 2 is set.
- R10: A push to a full queue is dropped and sets sticky status bit 3. A pop from an empty queue changes nothing, sets sticky status bit 4, and a data-port read of an empty queue returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on data address) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| eng_tx_pop | input | 1 | Engine takes the transmit head byte |
| eng_tx_byte | output | 8 | Transmit head byte |
| eng_tx_avail | output | 1 | Transmit queue not empty |
| eng_tx_sent | input | 1 | Engine finished shifting out a byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_rx_room | output | 1 | Receive queue not full |
| eng_hold | output | 1 | Request to hold the bus clock low |
| irq | output | 1 | Masked flag interrupt |

## Verification
A vector table first runs a short transmit and receive exchange with the receive mark at four bytes. Walking the transmit count down past the mark separates a level comparison from an edge detector. Status writes with mixed ones and zeros show that the write clears only the bits written as 0 and that a flag whose condition still holds comes back. The transmit mark is then switched through codes 2, 1 and 3 while the queue drains. This shows that each code picks its own threshold rather than a shared one.

Directed runs fill each queue to 17 entries and drain it completely. They use the largest receive mark, where the flag must fire at exactly 16. They check the 16-byte order and that the 17th byte is dropped. They also pop both queues while empty and flush one queue while the other holds data.

// File: rtl/i2c_fifo_pkg.sv
package i2c_fifo_pkg;

   localparam int BUS_W  = 8;
   localparam int ADDR_W = 3;
   localparam int FLAG_N = 5;

   typedef enum logic [ADDR_W-1:0] {
      SEL_DATA  = 3'd0,
      SEL_CTRL  = 3'd1,
      SEL_STAT  = 3'd2,
      SEL_IEN   = 3'd3,
      SEL_RXCNT = 3'd4,
      SEL_TXCNT = 3'd5
   } reg_sel_e;

   localparam int FLG_TXLOW = 0;
   localparam int FLG_RXHI  = 1;
   localparam int FLG_TEND  = 2;
   localparam int FLG_OVF   = 3;
   localparam int FLG_UNF   = 4;

   // low-water mark of the transmit queue for a 2-bit code
   function automatic int tx_mark(input int depth, input logic [1:0] code);
      if (code == 2'd3) return 0;
      return depth >> (int'(code) + 1);
   endfunction

endpackage

// File: rtl/i2c_fifo_buf.sv
module i2c_fifo_buf #(
   parameter  int WIDTH = 8,
   parameter  int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [CNT_W-1:0] count,
   output logic             ovf_evt,
   output logic             unf_evt
);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("i2c_fifo_buf: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             full, empty, do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push & ~full & ~flush;
   assign do_pop  = pop & ~empty & ~flush;
   assign ovf_evt = push & full & ~flush;
   assign unf_evt = pop & empty & ~flush;
   assign dout    = empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
         if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
         count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

endmodule

// File: rtl/i2c_fifo_flags.sv
module i2c_fifo_flags
   import i2c_fifo_pkg::*;
#(
   parameter  int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int LVL_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  rx_cnt,
   input  logic [CNT_W-1:0]  tx_cnt,
   input  logic [LVL_W-1:0]  rx_lvl,
   input  logic [1:0]        tx_code,
   input  logic              tx_sent,
   input  logic              ovf_evt,
   input  logic              unf_evt,
   input  logic              clr_we,
   input  logic [FLAG_N-1:0] clr_keep,
   output logic [FLAG_N-1:0] stat
);

   logic [FLAG_N-1:0] set_v;

   always_comb begin
      set_v            = '0;
      set_v[FLG_TXLOW] = (tx_cnt <= CNT_W'(tx_mark(DEPTH, tx_code)));
      set_v[FLG_RXHI]  = (rx_cnt >= (CNT_W'(rx_lvl) + CNT_W'(1)));
      set_v[FLG_TEND]  = tx_sent & (tx_cnt == '0);
      set_v[FLG_OVF]   = ovf_evt;
      set_v[FLG_UNF]   = unf_evt;
   end

   for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
      logic keep;
      assign keep = clr_we ? clr_keep[i] : 1'b1;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stat[i] <= 1'b0;
         else        stat[i] <= (stat[i] & keep) | set_v[i];
      end
   end

endmodule

// File: rtl/i2c_fifo_pair.sv
module i2c_fifo_pair
   import i2c_fifo_pkg::*;
#(
   parameter  int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int LVL_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              eng_tx_pop,
   output logic [BUS_W-1:0]  eng_tx_byte,
   output logic              eng_tx_avail,
   input  logic              eng_tx_sent,
   input  logic              eng_rx_push,
   input  logic [BUS_W-1:0]  eng_rx_byte,
   output logic              eng_rx_room,
   output logic              eng_hold,
   output logic              irq
);

   if (DEPTH != 8 && DEPTH != 16) begin : g_bad_depth
      $error("i2c_fifo_pair: receive level field fits DEPTH of 8 or 16 only");
   end

   logic [LVL_W-1:0]  rx_lvl_q;
   logic [1:0]        tx_code_q;
   logic [2:0]        ien_q;
   logic [FLAG_N-1:0] stat;
   logic [CNT_W-1:0]  rx_cnt, tx_cnt;
   logic [BUS_W-1:0]  rx_head;
   logic              wr_data, wr_ctrl, wr_stat, wr_ien;
   logic              push_tx, pop_rx, flush_tx, flush_rx;
   logic              tx_ovf, tx_unf, rx_ovf, rx_unf;
   logic [BUS_W-1:0]  ctrl_rd;

   assign wr_data  = bus_wr && (bus_addr == SEL_DATA);
   assign wr_ctrl  = bus_wr && (bus_addr == SEL_CTRL);
   assign wr_stat  = bus_wr && (bus_addr == SEL_STAT);
   assign wr_ien   = bus_wr && (bus_addr == SEL_IEN);
   assign push_tx  = wr_data;
   assign pop_rx   = bus_rd && (bus_addr == SEL_DATA);
   assign flush_tx = wr_ctrl & bus_wdata[0];
   assign flush_rx = wr_ctrl & bus_wdata[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_lvl_q  <= '0;
         tx_code_q <= '0;
         ien_q     <= '0;
      end else begin
         if (wr_ctrl) begin
            rx_lvl_q  <= bus_wdata[4 +: LVL_W];
            tx_code_q <= bus_wdata[3:2];
         end
         if (wr_ien) ien_q <= bus_wdata[2:0];
      end
   end

   i2c_fifo_buf #(.WIDTH(BUS_W), .DEPTH(DEPTH)) u_tx_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush_tx),
      .push    (push_tx),
      .din     (bus_wdata),
      .pop     (eng_tx_pop),
      .dout    (eng_tx_byte),
      .count   (tx_cnt),
      .ovf_evt (tx_ovf),
      .unf_evt (tx_unf)
   );

   i2c_fifo_buf #(.WIDTH(BUS_W), .DEPTH(DEPTH)) u_rx_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush_rx),
      .push    (eng_rx_push),
      .din     (eng_rx_byte),
      .pop     (pop_rx),
      .dout    (rx_head),
      .count   (rx_cnt),
      .ovf_evt (rx_ovf),
      .unf_evt (rx_unf)
   );

   i2c_fifo_flags #(.DEPTH(DEPTH)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_cnt   (rx_cnt),
      .tx_cnt   (tx_cnt),
      .rx_lvl   (rx_lvl_q),
      .tx_code  (tx_code_q),
      .tx_sent  (eng_tx_sent),
      .ovf_evt  (tx_ovf | rx_ovf),
      .unf_evt  (tx_unf | rx_unf),
      .clr_we   (wr_stat),
      .clr_keep (bus_wdata[FLAG_N-1:0]),
      .stat     (stat)
   );

   always_comb begin
      ctrl_rd              = '0;
      ctrl_rd[4 +: LVL_W]  = rx_lvl_q;
      ctrl_rd[3:2]         = tx_code_q;
   end

   always_comb begin
      case (bus_addr)
         SEL_DATA:  bus_rdata = rx_head;
         SEL_CTRL:  bus_rdata = ctrl_rd;
         SEL_STAT:  bus_rdata = BUS_W'(stat);
         SEL_IEN:   bus_rdata = BUS_W'(ien_q);
         SEL_RXCNT: bus_rdata = BUS_W'(rx_cnt);
         SEL_TXCNT: bus_rdata = BUS_W'(tx_cnt);
         default:   bus_rdata = '0;
      endcase
   end

   assign eng_tx_avail = (tx_cnt != '0);
   assign eng_rx_room  = (rx_cnt != CNT_W'(DEPTH));
   assign eng_hold     = stat[FLG_RXHI] | stat[FLG_TEND];
   assign irq          = |(stat[2:0] & ien_q);

endmodule

// File: rtl/i2c_fifo_pair_chk.sv
module i2c_fifo_pair_chk #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5,
   parameter int LVL_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] rx_cnt,
   input logic [CNT_W-1:0] tx_cnt,
   input logic             push_tx,
   input logic             flush_tx,
   input logic             eng_tx_pop,
   input logic             eng_tx_sent,
   input logic [4:0]       stat,
   input logic [LVL_W-1:0] rx_lvl_q,
   input logic [2:0]       ien_q,
   input logic             irq
);

   AST_RX_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rx_cnt) <= DEPTH);                                                        // R2

   AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(tx_cnt) == DEPTH && push_tx && !eng_tx_pop && !flush_tx)
      |=> (int'(tx_cnt) == DEPTH && stat[3]));                                       // R10

   AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      flush_tx |=> (tx_cnt == '0));                                                  // R3

   AST_RX_MARK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rx_cnt) >= int'(rx_lvl_q) + 1) |=> stat[1]);                             // R4

   AST_TEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_tx_sent && tx_cnt == '0) |=> stat[2]);                                    // R6

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == 3'b000) |-> !irq);                                                   // R8

endmodule

bind i2c_fifo_pair i2c_fifo_pair_chk #(
   .DEPTH (DEPTH),
   .CNT_W (CNT_W),
   .LVL_W (LVL_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_cnt      (rx_cnt),
   .tx_cnt      (tx_cnt),
   .push_tx     (push_tx),
   .flush_tx    (flush_tx),
   .eng_tx_pop  (eng_tx_pop),
   .eng_tx_sent (eng_tx_sent),
   .stat        (stat),
   .rx_lvl_q    (rx_lvl_q),
   .ien_q       (ien_q),
   .irq         (irq)
);

// File: tb/i2c_fifo_pair_tb.sv
module i2c_fifo_pair_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       eng_tx_pop = 1'b0, eng_tx_sent = 1'b0, eng_rx_push = 1'b0;
   logic [7:0] eng_tx_byte, eng_rx_byte = '0;
   logic       eng_tx_avail, eng_rx_room, eng_hold, irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   i2c_fifo_pair u_dut (
      .clk (clk), .rst_n (rst_n),
      .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .eng_tx_pop (eng_tx_pop), .eng_tx_byte (eng_tx_byte),
      .eng_tx_avail (eng_tx_avail), .eng_tx_sent (eng_tx_sent),
      .eng_rx_push (eng_rx_push), .eng_rx_byte (eng_rx_byte),
      .eng_rx_room (eng_rx_room), .eng_hold (eng_hold), .irq (irq)
   );

   localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_ID = 3'd2, OP_ERX = 3'd3,
                          OP_ETX = 3'd4, OP_SENT = 3'd5, OP_OUT = 3'd6;
   localparam logic [2:0] A_DATA = 3'd0, A_CTRL = 3'd1, A_STAT = 3'd2, A_IEN = 3'd3,
                          A_RXC = 3'd4, A_TXC = 3'd5;
   localparam logic [7:0] Z = 8'h00;
   localparam logic [3:0] NR = 4'd0;

   typedef logic [25:0] vec_t;   // op, addr, data, expect, requirement
   localparam int NV = 72;
   localparam vec_t VEC [NV] = '{
      {OP_RD,  A_STAT, Z,     8'h01, 4'd5},   // R5 empty tx below mark 8
      {OP_WR,  A_STAT, Z,     Z,     NR},
      {OP_ID,  A_DATA, Z,     Z,     NR},
      {OP_RD,  A_STAT, Z,     8'h01, 4'd7},   // R7 condition holds, flag returns
      {OP_WR,  A_CTRL, 8'h38, Z,     NR},
      {OP_RD,  A_CTRL, Z,     8'h38, 4'd3},   // R3 fields stored
      {OP_WR,  A_DATA, 8'hA1, Z,     NR},
      {OP_WR,  A_DATA, 8'hA2, Z,     NR},
      {OP_WR,  A_DATA, 8'hA3, Z,     NR},
      {OP_RD,  A_TXC,  Z,     8'h03, 4'd2},   // R2
      {OP_WR,  A_STAT, Z,     Z,     NR},
      {OP_ID,  A_DATA, Z,     Z,     NR},
      {OP_RD,  A_STAT, Z,     8'h00, 4'd5},   // R5 3 above mark 2
      {OP_ETX, A_DATA, Z,     8'hA1, 4'd2},
      {OP_RD,  A_TXC,  Z,     8'h02, 4'd2},
      {OP_ID,  A_DATA, Z,     Z,     NR},
      {OP_RD,  A_STAT, Z,     8'h01, 4'd5},   // R5 2 reaches mark 2
      {OP_ERX, A_DATA, 8'h11, Z,     NR},
      {OP_ERX, A_DATA, 8'h22, Z,     NR},
      {OP_ERX, A_DATA, 8'h33, Z,     NR},
      {OP_ID,  A_DATA, Z,     Z,     NR},
      {OP_RD,  A_STAT, Z,     8'h01, 4'd4},   // R4 3 below N+1=4
      {OP_RD,  A_RXC,  Z,     8'h03, 4'd2},
      {OP_ERX, A_DATA, 8'h44, Z,     NR},
      {OP_ID,  A_DATA, Z,     Z,     NR},
      {OP_RD,  A_STAT, Z,     8'h03, 4'd4},   // R4
      {OP_OUT, A_DATA, Z,     8'h01, 4'd9},   // R9
      {OP_WR,  A_IEN,  8'h02, Z,     NR},
      {OP_OUT, A_DATA, Z,     8'h03, 4'd8},   // R8
      {OP_RD,  A_DATA, Z,     8'h11, 4'd2},
      {OP_RD,  A_DATA, Z,     8'h22, 4'd2},
      {OP_RD,  A_RXC,  Z,     8'h02, 4'd2},
      {OP_WR,  A_STAT, 8'h01, Z,     NR},
      {OP_ID,  A_DATA, Z,     Z,     NR},
      {OP_RD,  A_STAT, Z,     8'h01, 4'd7},   // R7 written-1 bit kept
      {OP_OUT, A_DATA, Z,     8'h00, 4'd9},
      {OP_ETX, A_DATA, Z,     8'hA2, 4'd2},
      {OP_ETX, A_DATA, Z,     8'hA3, 4'd2},
      {OP_RD,  A_TXC,  Z,     8'h00, 4'd2},
      {OP_SENT,A_DATA, Z,     Z,     NR},
      {OP_ID,  A_DATA, Z,     Z,     NR},
      {OP_RD,  A_STAT, Z,     8'h05, 4'd6},   // R6
      {OP_OUT, A_DATA, Z,     8'h01, 4'd9},
      {OP_WR,  A_IEN,  8'h04, Z,     NR},
      {OP_OUT, A_DATA, Z,     8'h03, 4'd8},
      {OP_WR,  A_STAT, 8'h03, Z,     NR},
      {OP_ID,  A_DATA, Z,     Z,     NR},
      {OP_RD,  A_STAT, Z,     8'h01, 4'd7},
      {OP_OUT, A_DATA, Z,     8'h00, 4'd9},
      {OP_WR,  A_CTRL, 8'h34, Z,     NR},
      {OP_WR,  A_DATA, 8'hB1, Z,     NR},
      {OP_WR,  A_DATA, 8'hB2, Z,     NR},
      {OP_WR,  A_DATA, 8'hB3, Z,     NR},
      {OP_WR,  A_DATA, 8'hB4, Z,     NR},
      {OP_WR,  A_DATA, 8'hB5, Z,     NR},
      {OP_RD,  A_TXC,  Z,     8'h05, 4'd2},
      {OP_WR,  A_STAT, Z,     Z,     NR},
      {OP_ID,  A_DATA, Z,     Z,     NR},
      {OP_RD,  A_STAT, Z,     8'h00, 4'd5},   // R5 code 1: 5 above 4
      {OP_ETX, A_DATA, Z,     8'hB1, 4'd2},
      {OP_ID,  A_DATA, Z,     Z,     NR},
      {OP_RD,  A_STAT, Z,     8'h01, 4'd5},   // R5 code 1: 4 reaches 4
      {OP_WR,  A_CTRL, 8'h3C, Z,     NR},
      {OP_WR,  A_STAT, Z,     Z,     NR},
      {OP_ID,  A_DATA, Z,     Z,     NR},
      {OP_RD,  A_STAT, Z,     8'h00, 4'd5},   // R5 code 3: 4 above 0
      {OP_ETX, A_DATA, Z,     8'hB2, 4'd2},
      {OP_ETX, A_DATA, Z,     8'hB3, 4'd2},
      {OP_ETX, A_DATA, Z,     8'hB4, 4'd2},
      {OP_ETX, A_DATA, Z,     8'hB5, 4'd2},
      {OP_ID,  A_DATA, Z,     Z,     NR},
      {OP_RD,  A_STAT, Z,     8'h01, 4'd5}    // R5 code 3: empty
   };

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input int req,
                      input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input int req);
      bus_rd = 1'b1; bus_addr = a;
      #1 chk(bus_rdata, exp, req, $sformatf("read addr %0d", a));
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic erx(input logic [7:0] d);
      eng_rx_push = 1'b1; eng_rx_byte = d;
      @(negedge clk);
      eng_rx_push = 1'b0;
   endtask

   task automatic etx(input logic [7:0] exp, input int req);
      eng_tx_pop = 1'b1;
      #1 chk(eng_tx_byte, exp, req, "engine tx byte");
      @(negedge clk);
      eng_tx_pop = 1'b0;
   endtask

   task automatic reset_state_check(input string tag);
      bus_addr = A_STAT; #1 chk(bus_rdata, 8'h00, 1, {tag, " status"});      // R1
      bus_addr = A_CTRL; #1 chk(bus_rdata, 8'h00, 1, {tag, " control"});
      bus_addr = A_IEN;  #1 chk(bus_rdata, 8'h00, 1, {tag, " enable"});
      bus_addr = A_RXC;  #1 chk(bus_rdata, 8'h00, 1, {tag, " rx count"});
      bus_addr = A_TXC;  #1 chk(bus_rdata, 8'h00, 1, {tag, " tx count"});
      chk({4'b0, irq, eng_hold, eng_tx_avail, eng_rx_room}, 8'h01, 1, {tag, " outputs"});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      reset_state_check("R1 at reset");
      rst_n = 1'b1;
      @(negedge clk);

      // vector table walk
      for (int i = 0; i < NV; i++) begin
         vec_t v;
         v = VEC[i];
         case (v[25:23])
            OP_WR:   wr(v[22:20], v[19:12]);
            OP_RD:   rd(v[22:20], v[11:4], int'(v[3:0]));
            OP_ERX:  erx(v[19:12]);
            OP_ETX:  etx(v[11:4], int'(v[3:0]));
            OP_SENT: begin
               eng_tx_sent = 1'b1;
               @(negedge clk);
               eng_tx_sent = 1'b0;
            end
            OP_OUT: begin
               chk({6'b0, irq, eng_hold}, v[11:4], int'(v[3:0]), "irq/hold");
               @(negedge clk);
            end
            default: idle();
         endcase
      end

      // R3 flushes act on one queue only; reset bits read as 0
      wr(A_CTRL, 8'h3E);
      rd(A_RXC, 8'h00, 3);
      rd(A_CTRL, 8'h3C, 3);
      wr(A_DATA, 8'hC1);
      wr(A_DATA, 8'hC2);
      erx(8'h55);
      wr(A_CTRL, 8'h3D);
      rd(A_TXC, 8'h00, 3);
      rd(A_RXC, 8'h01, 3);
      wr(A_CTRL, 8'h3E);
      rd(A_RXC, 8'h00, 3);

      // R4 largest mark N=15 fires at exactly 16
      wr(A_CTRL, 8'hF0);
      wr(A_IEN, 8'h00);
      wr(A_STAT, 8'h00);
      for (int i = 0; i < 15; i++) erx(8'h60 + 8'(i));
      idle();
      rd(A_STAT, 8'h01, 4);
      erx(8'h6F);
      idle();
      rd(A_STAT, 8'h03, 4);
      // R10 17th receive byte dropped
      erx(8'h70);
      rd(A_RXC, 8'h10, 10);
      idle();
      rd(A_STAT, 8'h0B, 10);
      for (int i = 0; i < 16; i++) rd(A_DATA, 8'h60 + 8'(i), 2);
      wr(A_STAT, 8'h00);
      idle();
      rd(A_STAT, 8'h01, 7);
      // R10 read of empty receive queue
      rd(A_DATA, 8'h00, 10);
      idle();
      rd(A_STAT, 8'h11, 10);
      rd(A_RXC, 8'h00, 10);

      // R10 transmit overflow and order of the kept 16
      wr(A_STAT, 8'h00);
      for (int i = 0; i < 17; i++) wr(A_DATA, 8'h80 + 8'(i));
      rd(A_TXC, 8'h10, 10);
      idle();
      rd(A_STAT, 8'h09, 10);
      for (int i = 0; i < 16; i++) etx(8'h80 + 8'(i), 2);
      rd(A_TXC, 8'h00, 2);
      wr(A_STAT, 8'h00);
      eng_tx_pop = 1'b1;
      @(negedge clk);
      eng_tx_pop = 1'b0;
      idle();
      rd(A_STAT, 8'h11, 10);
      rd(A_TXC, 8'h00, 10);

      // R7 writing ones clears nothing
      wr(A_STAT, 8'hFF);
      idle();
      rd(A_STAT, 8'h11, 7);

      // R1 reset in mid-run
      wr(A_IEN, 8'h07);
      erx(8'h99);
      rst_n = 1'b0;
      @(negedge clk);
      reset_state_check("R1 mid-run");
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule